// File: doc/BRIEF.md
# Single-to-Half Precision Narrowing Converter

This block turns a binary32 floating-point operand into a binary16 value under round-to-nearest, ties-to-even. An operand is presented with a valid strobe. The result comes out with its own valid strobe exactly one clock later. There is no backpressure, so a new operand may be accepted on every cycle.

The input is split into sign, biased exponent and fraction. Each operand then takes one of four paths:

- **In-range path.** The exponent is rebiased and the fraction is rounded.
- **NaN path.** The result is a NaN whose quiet bit is forced high and which keeps a truncated payload.
- **Overflow path.** The result saturates to a signed infinity.
- **Underflow path.** The operand is denormalized with a sticky bit and then rounded into a subnormal, a zero, or the smallest normal.

The in-range and underflow paths share one rounder. A carry out of the fraction field moves into the exponent field.

All field widths are parameters. The same source can therefore be built for binary64 to binary32.

Top module: `fpn_narrow`

## Requirements
- R1: `out_valid` is low after a synchronous reset. On every later cycle it equals the value `in_valid` had one cycle earlier.
- R2: For every input class, bit 15 of the result (the sign) equals bit 31 of the operand.
- R3: An operand with biased exponent (bits 30:23) in 113..142 gives a result with exponent field (bits 14:10) equal to that exponent minus 112. The fraction is input bits 22:13, rounded using the dropped bits 12:0 against 0x1000:
  - above 0x1000: add one;
  - equal to 0x1000: add the current fraction LSB;
  - below 0x1000: keep the fraction unchanged.
- R4: When rounding carries out of the 10-bit fraction, the fraction becomes zero and the exponent field goes up by one. For example, 0x477FF000 gives 0x7C00, while 0x477FE000 gives 0x7BFF.
- R5: A NaN operand (exponent 255, fraction nonzero) gives:
  - exponent field 31;
  - bit 9 set;
  - bits 8:0 equal to operand bits 21:13.
- R6: An operand with biased exponent 143..254, or an infinity, gives a signed infinity: exponent field 31 and fraction 0.
- R7: An operand with biased exponent 90..112 gives a subnormal or zero result. The significand, including the hidden one, is shifted right by 113 minus the exponent. Any nonzero shifted-out bit is ORed into the LSB, and the value is then rounded as in R3.
- R8: An operand with biased exponent 0..89, including zeros and binary32 subnormals, gives a signed zero.
- R9: A subnormal result that rounds past 0x03FF becomes 0x0400, which is exponent field 1 and fraction 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand strobe |
| in_data | input | 1+SRC_EXP+SRC_FRAC (32) | Wide-format operand |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_data | output | 1+DST_EXP+DST_FRAC (16) | Narrow-format result |

## Verification
The assertions check the following on every cycle:

- strobe timing;
- sign transfer;
- forced quiet bit and all-ones exponent of NaN results;
- saturation of overflowing operands to infinity;
- zeroing of operands below the subnormal range;
- the rounder's rule that a carry out leaves a zero fraction;
- the denormalizer never leaving a bit above the fraction field.

Only the bench scenarios can show that rounded values are numerically right. These scenarios cover:

- ties on even and odd LSBs;
- sticky-bit effects on a tie;
- the exact boundary between the largest finite value and infinity;
- the carry from the largest subnormal into the smallest normal;
- payload placement in NaNs.

// File: rtl/fpn_pkg.sv
package fpn_pkg;

   // Which result path an operand takes through the converter.
   typedef enum logic [1:0] {
      PATH_NORM  = 2'd0,
      PATH_NAN   = 2'd1,
      PATH_INF   = 2'd2,
      PATH_UNDER = 2'd3
   } fpn_path_e;

endpackage

// File: rtl/fpn_classify.sv
module fpn_classify
   import fpn_pkg::*;
#(
   parameter int SRC_EXP = 8,
   parameter int DST_EXP = 5
) (
   input  logic [SRC_EXP-1:0] exp_i,
   input  logic               frac_nz_i,
   output fpn_path_e          path_o,
   output logic [DST_EXP-1:0] base_exp_o
);

   localparam int SRC_BIAS = (1 << (SRC_EXP - 1)) - 1;
   localparam int DST_BIAS = (1 << (DST_EXP - 1)) - 1;
   localparam int DST_MAX  = (1 << DST_EXP) - 1;
   localparam int REBIAS   = SRC_BIAS - DST_BIAS;
   localparam int NORM_LO  = REBIAS + 1;
   localparam int NORM_HI  = REBIAS + DST_MAX - 1;
   localparam int OVF_EXP  = REBIAS + DST_MAX;

   localparam logic [SRC_EXP-1:0] LO_V   = SRC_EXP'(NORM_LO);
   localparam logic [SRC_EXP-1:0] HI_V   = SRC_EXP'(NORM_HI);
   localparam logic [SRC_EXP-1:0] OVF_V  = SRC_EXP'(OVF_EXP);
   localparam logic [SRC_EXP-1:0] REB_V  = SRC_EXP'(REBIAS);
   localparam logic [SRC_EXP-1:0] ONES_V = {SRC_EXP{1'b1}};

   // Priority: in-range normal, then NaN, then overflow, otherwise underflow.
   always_comb begin
      if (exp_i >= LO_V && exp_i <= HI_V)
         path_o = PATH_NORM;
      else if (exp_i == ONES_V && frac_nz_i)
         path_o = PATH_NAN;
      else if (exp_i >= OVF_V)
         path_o = PATH_INF;
      else
         path_o = PATH_UNDER;
   end

   // Rebiased exponent; only meaningful on the in-range path.
   assign base_exp_o = DST_EXP'(exp_i - REB_V);

endmodule

// File: rtl/fpn_denorm.sv
module fpn_denorm #(
   parameter int SRC_EXP  = 8,
   parameter int SRC_FRAC = 23,
   parameter int DST_EXP  = 5,
   parameter int DST_FRAC = 10
) (
   input  logic [SRC_EXP-1:0]             exp_i,
   input  logic [SRC_FRAC-1:0]            frac_i,
   output logic [DST_FRAC-1:0]            frac_o,
   output logic [SRC_FRAC-DST_FRAC-1:0]   tail_o,
   output logic                           top_o,
   output logic                           flush_o
);

   localparam int TAIL     = SRC_FRAC - DST_FRAC;
   localparam int SIG_W    = SRC_FRAC + 1;
   localparam int SH_W     = SRC_EXP + 1;
   localparam int SRC_BIAS = (1 << (SRC_EXP - 1)) - 1;
   localparam int DST_BIAS = (1 << (DST_EXP - 1)) - 1;
   localparam logic [SH_W-1:0] SH_BASE = SH_W'(SRC_BIAS - DST_BIAS);
   localparam logic [SH_W-1:0] SH_MAX  = SH_W'(SRC_FRAC);

   logic              exp_nz;
   logic [SH_W-1:0]   shamt;
   logic [SIG_W-1:0]  sig;
   logic [SIG_W-1:0]  shifted;
   logic [SIG_W-1:0]  lost;
   logic [SIG_W-1:0]  dn;
   logic              sticky;

   assign exp_nz = |exp_i;
   // A normal operand carries its hidden one and needs one more place of shift.
   assign shamt  = SH_BASE - {1'b0, exp_i} + SH_W'(exp_nz);
   assign sig    = {exp_nz, frac_i};
   assign shifted = sig >> shamt;

   // One comparator per significand bit marks the bits that fall off the end.
   for (genvar i = 0; i < SIG_W; i++) begin : g_lost
      assign lost[i] = sig[i] & (SH_W'(i) < shamt);
   end

   assign sticky  = |lost;
   assign dn      = {shifted[SIG_W-1:1], shifted[0] | sticky};
   assign flush_o = shamt > SH_MAX;
   assign frac_o  = dn[TAIL+DST_FRAC-1:TAIL];
   assign tail_o  = dn[TAIL-1:0];
   assign top_o   = dn[SIG_W-1];

endmodule

// File: rtl/fpn_rne.sv
module fpn_rne #(
   parameter int EXP_W  = 5,
   parameter int FRAC_W = 10,
   parameter int TAIL_W = 13
) (
   input  logic [EXP_W-1:0]  exp_i,
   input  logic [FRAC_W-1:0] frac_i,
   input  logic [TAIL_W-1:0] tail_i,
   output logic [EXP_W-1:0]  exp_o,
   output logic [FRAC_W-1:0] frac_o
);

   localparam logic [TAIL_W-1:0] HALF = TAIL_W'(1) << (TAIL_W - 1);

   logic              bump;
   logic [FRAC_W:0]   sum;

   // Nearest wins; an exact half goes toward an even fraction.
   always_comb begin
      if (tail_i > HALF)
         bump = 1'b1;
      else if (tail_i == HALF)
         bump = frac_i[0];
      else
         bump = 1'b0;
   end

   assign sum    = {1'b0, frac_i} + (FRAC_W + 1)'(bump);
   // Carry out of the fraction moves into the exponent; the fraction wraps to zero.
   assign frac_o = sum[FRAC_W-1:0];
   assign exp_o  = exp_i + EXP_W'(sum[FRAC_W]);

endmodule

// File: rtl/fpn_narrow.sv
module fpn_narrow
   import fpn_pkg::*;
#(
   parameter int SRC_EXP  = 8,
   parameter int SRC_FRAC = 23,
   parameter int DST_EXP  = 5,
   parameter int DST_FRAC = 10
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           in_valid,
   input  logic [SRC_EXP+SRC_FRAC:0]      in_data,
   output logic                           out_valid,
   output logic [DST_EXP+DST_FRAC:0]      out_data
);

   localparam int SRC_W   = 1 + SRC_EXP + SRC_FRAC;
   localparam int DST_W   = 1 + DST_EXP + DST_FRAC;
   localparam int TAIL    = SRC_FRAC - DST_FRAC;
   localparam int SRC_BIAS = (1 << (SRC_EXP - 1)) - 1;
   localparam int DST_BIAS = (1 << (DST_EXP - 1)) - 1;
   localparam int OVF_EXP = SRC_BIAS - DST_BIAS + (1 << DST_EXP) - 1;
   localparam int FLUSH_BELOW = SRC_BIAS - DST_BIAS - SRC_FRAC;

   // Elaboration-time parameter checks.
   if (SRC_EXP <= DST_EXP) begin : g_bad_exp
      $error("fpn_narrow: source exponent must be wider than destination");
   end
   if (SRC_FRAC <= DST_FRAC) begin : g_bad_frac
      $error("fpn_narrow: source fraction must be wider than destination");
   end
   if (DST_FRAC < 2) begin : g_bad_dfrac
      $error("fpn_narrow: destination fraction needs a quiet bit and a payload bit");
   end

   logic                 sgn;
   logic [SRC_EXP-1:0]   s_exp;
   logic [SRC_FRAC-1:0]  s_frac;
   fpn_path_e            path;
   logic [DST_EXP-1:0]   base_exp;

   logic [DST_FRAC-1:0]  dn_frac;
   logic [TAIL-1:0]      dn_tail;
   logic                 dn_top;
   logic                 dn_flush;

   logic [DST_EXP-1:0]   r_exp_in;
   logic [DST_FRAC-1:0]  r_frac_in;
   logic [TAIL-1:0]      r_tail_in;
   logic [DST_EXP-1:0]   r_exp;
   logic [DST_FRAC-1:0]  r_frac;

   logic [DST_W-1:0]     result;

   assign sgn    = in_data[SRC_W-1];
   assign s_exp  = in_data[SRC_FRAC +: SRC_EXP];
   assign s_frac = in_data[SRC_FRAC-1:0];

   fpn_classify #(
      .SRC_EXP (SRC_EXP),
      .DST_EXP (DST_EXP)
   ) u_class (
      .exp_i      (s_exp),
      .frac_nz_i  (|s_frac),
      .path_o     (path),
      .base_exp_o (base_exp)
   );

   fpn_denorm #(
      .SRC_EXP  (SRC_EXP),
      .SRC_FRAC (SRC_FRAC),
      .DST_EXP  (DST_EXP),
      .DST_FRAC (DST_FRAC)
   ) u_denorm (
      .exp_i   (s_exp),
      .frac_i  (s_frac),
      .frac_o  (dn_frac),
      .tail_o  (dn_tail),
      .top_o   (dn_top),
      .flush_o (dn_flush)
   );

   // One rounder serves both the in-range and the subnormal path.
   always_comb begin
      if (path == PATH_NORM) begin
         r_exp_in  = base_exp;
         r_frac_in = s_frac[SRC_FRAC-1:TAIL];
         r_tail_in = s_frac[TAIL-1:0];
      end else begin
         r_exp_in  = '0;
         r_frac_in = dn_frac;
         r_tail_in = dn_tail;
      end
   end

   fpn_rne #(
      .EXP_W  (DST_EXP),
      .FRAC_W (DST_FRAC),
      .TAIL_W (TAIL)
   ) u_rne (
      .exp_i  (r_exp_in),
      .frac_i (r_frac_in),
      .tail_i (r_tail_in),
      .exp_o  (r_exp),
      .frac_o (r_frac)
   );

   always_comb begin
      unique case (path)
         PATH_NAN:
            result = {sgn, {DST_EXP{1'b1}}, 1'b1, s_frac[TAIL+DST_FRAC-2:TAIL]};
         PATH_INF:
            result = {sgn, {DST_EXP{1'b1}}, {DST_FRAC{1'b0}}};
         PATH_UNDER:
            result = dn_flush ? {sgn, {(DST_W-1){1'b0}}} : {sgn, r_exp, r_frac};
         default:
            result = {sgn, r_exp, r_frac};
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)
         out_valid <= 1'b0;
      else
         out_valid <= in_valid;
      if (in_valid)
         out_data <= result;
   end

   // Strobe follows the operand strobe by one cycle.
   assert_valid_rise_R1: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
   assert_valid_drop_R1: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   // Sign passes through every path.
   assert_sign_R2: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_data[DST_W-1] == $past(in_data[SRC_W-1]));

   // A rounding carry always leaves an empty fraction behind.
   assert_carry_clear_R4: assert property (@(posedge clk) disable iff (rst)
      (r_exp != r_exp_in) |-> (r_frac == '0));

   // NaN results are quiet with an all-ones exponent.
   assert_nan_quiet_R5: assert property (@(posedge clk) disable iff (rst)
      in_valid && (in_data[SRC_FRAC +: SRC_EXP] == {SRC_EXP{1'b1}}) && (|in_data[SRC_FRAC-1:0])
      |=> (out_data[DST_FRAC +: DST_EXP] == {DST_EXP{1'b1}}) && out_data[DST_FRAC-1]);

   // Overflowing operands saturate to infinity.
   assert_inf_R6: assert property (@(posedge clk) disable iff (rst)
      in_valid && (int'(in_data[SRC_FRAC +: SRC_EXP]) >= OVF_EXP)
      && !((in_data[SRC_FRAC +: SRC_EXP] == {SRC_EXP{1'b1}}) && (|in_data[SRC_FRAC-1:0]))
      |=> (out_data[DST_W-2:0] == {{DST_EXP{1'b1}}, {DST_FRAC{1'b0}}}));

   // The denormalizer never leaves a bit above the destination fraction.
   assert_dn_headroom_R7: assert property (@(posedge clk) disable iff (rst)
      (path == PATH_UNDER) && !dn_flush |-> !dn_top);

   // Far below the subnormal range the magnitude is zero.
   assert_flush_R8: assert property (@(posedge clk) disable iff (rst)
      in_valid && (int'(in_data[SRC_FRAC +: SRC_EXP]) < FLUSH_BELOW)
      |=> (out_data[DST_W-2:0] == '0));

endmodule

// File: tb/fpn_narrow_test.sv
module fpn_narrow_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [31:0] in_data = '0;
   logic        out_valid;
   logic [15:0] out_data;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   fpn_narrow uut (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .out_valid (out_valid),
      .out_data  (out_data)
   );

   task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Independent model: round the exact value onto the target grid and let the
   // integer-coded encoding absorb carries into the exponent.
   function automatic logic [15:0] model(input logic [31:0] x);
      logic   s;
      int     e, ub, e2, qe, sh, eff;
      longint m, n, rem, half, bits;
      s = x[31];
      e = int'(x[30:23]);
      if (e == 255)
         return (x[22:0] != 0) ? {s, 5'h1F, 1'b1, x[21:13]} : {s, 15'h7C00};
      if (e == 0 && x[22:0] == 0)
         return {s, 15'h0};
      if (e == 0) begin
         m = longint'(x[22:0]); e2 = -149; ub = -127;
      end else begin
         m = longint'({1'b1, x[22:0]}); e2 = e - 150; ub = e - 127;
      end
      if (ub > 15)
         return {s, 15'h7C00};
      eff = (ub < -14) ? -14 : ub;
      qe  = eff - 10;
      sh  = qe - e2;
      if (sh > 40) begin
         n = 0; rem = m; half = 64'sd1 << 40;
      end else begin
         n = m >>> sh; rem = m - (n <<< sh); half = 64'sd1 <<< (sh - 1);
      end
      if (rem > half)
         n = n + 1;
      else if (rem == half)
         n = n + (n & 1);
      bits = longint'(eff + 14) * 1024 + n;
      if (bits >= 64'h7C00)
         bits = 64'h7C00;
      return {s, bits[14:0]};
   endfunction

   task automatic convert(input logic [31:0] x, input logic [15:0] exp, input string req);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = x;
      @(negedge clk);
      in_valid = 1'b0;
      check16({req, " valid"}, {15'h0, out_valid}, 16'h1);
      check16(req, out_data, exp);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check16("R1 reset", {15'h0, out_valid}, 16'h0);
   endtask

   task automatic t_strobe();
      // R1: idle cycle drops the strobe, back-to-back operands each appear once.
      convert(32'h3F800000, 16'h3C00, "R1");
      @(negedge clk);
      check16("R1 idle", {15'h0, out_valid}, 16'h0);
      in_valid = 1'b1; in_data = 32'h40000000;
      @(negedge clk);
      check16("R1 stream a", out_data, 16'h4000);
      in_data = 32'hC0400000;
      @(negedge clk);
      in_valid = 1'b0;
      check16("R1 stream b", out_data, 16'hC200);
      check16("R1 stream v", {15'h0, out_valid}, 16'h1);
      @(negedge clk);
      check16("R1 stream end", {15'h0, out_valid}, 16'h0);
   endtask

   task automatic t_sign();
      convert(32'h00000000, 16'h0000, "R2 +0");
      convert(32'h80000000, 16'h8000, "R2 -0");
      convert(32'hC0000000, 16'hC000, "R2 -2");
      convert(32'hFF800000, 16'hFC00, "R2 -inf");
      convert(32'hFFC00000, 16'hFE00, "R2 -nan");
   endtask

   task automatic t_normal();
      convert(32'h3F800000, 16'h3C00, "R3 one");
      convert(32'h38800000, 16'h0400, "R3 min normal");
      convert(32'h477FE000, 16'h7BFF, "R3 max normal");
      convert(32'h3F801000, 16'h3C00, "R3 tie even");
      convert(32'h3F803000, 16'h3C02, "R3 tie odd");
      convert(32'h3F801001, 16'h3C01, "R3 above half");
      convert(32'h3F800FFF, 16'h3C00, "R3 below half");
   endtask

   task automatic t_carry();
      convert(32'h3FFFF000, 16'h4000, "R4 carry");
      convert(32'h477FF000, 16'h7C00, "R4 carry to inf");
      convert(32'h477FEFFF, 16'h7BFF, "R4 stays finite");
   endtask

   task automatic t_nan();
      convert(32'h7FC00000, 16'h7E00, "R5 quiet");
      convert(32'h7F800001, 16'h7E00, "R5 signalling");
      convert(32'h7FA00000, 16'h7F00, "R5 payload top");
      convert(32'hFF80A000, 16'hFE05, "R5 payload low");
   endtask

   task automatic t_overflow();
      convert(32'h47800000, 16'h7C00, "R6 threshold");
      convert(32'h7F7FFFFF, 16'h7C00, "R6 max float");
      convert(32'h7F800000, 16'h7C00, "R6 +inf");
   endtask

   task automatic t_under();
      convert(32'h33800000, 16'h0001, "R7 min subnormal");
      convert(32'h33000000, 16'h0000, "R7 tie to zero");
      convert(32'h33000001, 16'h0001, "R7 sticky");
      convert(32'h33C00000, 16'h0002, "R7 tie odd");
      convert(32'h387FC000, 16'h03FF, "R7 max subnormal");
      convert(32'h32800000, 16'h0000, "R7 below half");
      convert(32'hAD7FFFFF, 16'h8000, "R7 deepest shift");
   endtask

   task automatic t_flush();
      convert(32'h2CFFFFFF, 16'h0000, "R8 exp 89");
      convert(32'h00000001, 16'h0000, "R8 subnormal in");
      convert(32'h807FFFFF, 16'h8000, "R8 neg subnormal in");
   endtask

   task automatic t_sub_carry();
      convert(32'h387FE000, 16'h0400, "R9 carry to normal");
      convert(32'hB87FF000, 16'h8400, "R9 negative");
   endtask

   task automatic t_random();
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] x;
         x = $urandom();
         if (i % 2 == 1)
            x[30:23] = 8'($urandom_range(88, 146));
         convert(x, model(x), "R3 R7 random");
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_strobe();
      t_sign();
      t_normal();
      t_carry();
      t_nan();
      t_overflow();
      t_under();
      t_flush();
      t_sub_carry();
      t_random();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule